// File: doc/BRIEF.md
# Two-Word Event Item Formatter

This block sits between the time-stamping front end of a pattern recorder and its output link. It takes records from four producers: two groups of pattern inputs, a SYNC marker, and a flow-control source that reports pause and resume. Each record carries a 48-bit timestamp and a 4-bit tracking tag. The block turns every accepted record into an item of two 32-bit words and sends them on a valid/ready stream. Pattern items carry a per-group source ident and the 16-bit pattern. Information items carry a module number, an information code and the upper timestamp bits. In both kinds, the second word holds the low 28 timestamp bits.

The block keeps its own running count of accepted records and compares it with the tag of each record it is about to take. When a tag is out of step, the record is refused and the block stops for good. A sticky lost-track status then stays high until reset. A bypass control turns the comparison off. Only one record is taken for each item. When several producers are waiting, a fixed priority picks one.

Top module: `evitem_fmt`

## Requirements
- R1: After reset, `item_vld` and `track_lost` are 0, and the internal expected tag is 0.
- R2: For a group item, the first word has bits 31:28 = 4'b1100, bits 27:16 = the group's ident (`ga_ident` or `gb_ident`) and bits 15:0 = the group's pattern.
- R3: For every item, the second word has bits 31:28 = 4'b0000 and bits 27:0 = timestamp bits 27:0.
- R4: For an information item, the first word has bits 31:30 = 2'b10, bits 29:24 = `unit_id`, bits 23:20 = the information code and bits 19:0 = timestamp bits 47:28.
- R5: The information codes are 4 for SYNC, 2 for pause (`flow_resume`=0) and 3 for resume (`flow_resume`=1). Code 0 is reserved for undefined.
- R6: The two words of an item go out first word then second word, with no other word in between. While `item_vld` is high and `item_rdy` is low, `item_word` holds its value.
- R7: When several producers are valid in the same cycle, exactly one is granted, in the fixed order SYNC, then flow, then group A, then group B.
- R8: The expected tag goes up by one, modulo 16, for each accepted record. A record whose tag equals the expected tag is accepted.
- R9: When the tag of the granted record differs from the expected tag (and bypass is off), that record is not accepted and `track_lost` rises on the next cycle. From then on no record is accepted and no item is sent until reset.
- R10: With `track_bypass`=1, records are accepted whatever their tag, and `track_lost` stays 0. The expected count still advances.
- R11: A record is accepted (its ready high) only in a cycle where no item is being sent (`item_vld` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_vld | input | 1 | SYNC record present |
| sync_rdy | output | 1 | SYNC record accepted this cycle |
| sync_stamp | input | 48 | SYNC timestamp |
| sync_tag | input | TRACK_W | SYNC tracking tag |
| flow_vld | input | 1 | Pause/resume record present |
| flow_rdy | output | 1 | Pause/resume record accepted this cycle |
| flow_resume | input | 1 | 1 = resume, 0 = pause |
| flow_stamp | input | 48 | Pause/resume timestamp |
| flow_tag | input | TRACK_W | Pause/resume tracking tag |
| ga_vld | input | 1 | Group A record present |
| ga_rdy | output | 1 | Group A record accepted this cycle |
| ga_bits | input | 16 | Group A pattern |
| ga_stamp | input | 48 | Group A timestamp |
| ga_tag | input | TRACK_W | Group A tracking tag |
| gb_vld | input | 1 | Group B record present |
| gb_rdy | output | 1 | Group B record accepted this cycle |
| gb_bits | input | 16 | Group B pattern |
| gb_stamp | input | 48 | Group B timestamp |
| gb_tag | input | TRACK_W | Group B tracking tag |
| ga_ident | input | 12 | Source ident placed in group A items |
| gb_ident | input | 12 | Source ident placed in group B items |
| unit_id | input | 6 | Module number placed in information items |
| track_bypass | input | 1 | 1 = skip the tag comparison |
| item_vld | output | 1 | Output word valid |
| item_rdy | input | 1 | Downstream takes the word |
| item_word | output | 32 | Output word |
| track_lost | output | 1 | Sticky tracking failure status |

## Verification
Arbitration and tracking can meet in one cycle. All four producers are raised together, and their tags are numbered in the order the priority is expected to serve them. The tracker therefore passes each grant only if the arbiter chose the right producer. A wrong choice shows up as a miscompare of the item order, and as a refused record. A second meeting point is the tag check and the output stall. Records are presented while the downstream stalls at random, and the bench checks that no ready rises while an item is still being sent. It also checks that both words of an item stay together.

// File: rtl/evitem_pkg.sv
package evitem_pkg;

    // Fixed by the item format
    localparam int WORD_W    = 32;
    localparam int TS_W      = 48;
    localparam int PAT_W     = 16;
    localparam int ID_W      = 12;
    localparam int MOD_W     = 6;
    localparam int CODE_W    = 4;
    localparam int LOW_TS_W  = 28;
    localparam int HIGH_TS_W = TS_W - LOW_TS_W;
    localparam int NSRC      = 4;
    localparam int SRC_W     = $clog2(NSRC);

    // Source index doubles as priority: lower index wins
    typedef enum logic [SRC_W-1:0] {
        SRC_SYNC = 2'd0,
        SRC_FLOW = 2'd1,
        SRC_GA   = 2'd2,
        SRC_GB   = 2'd3
    } src_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_UNDEF  = 4'd0,
        CODE_PAUSE  = 4'd2,
        CODE_RESUME = 4'd3,
        CODE_SYNC   = 4'd4
    } info_code_e;

    typedef struct packed {
        logic [WORD_W-1:0] head;
        logic [WORD_W-1:0] tail;
    } item_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    function automatic logic [WORD_W-1:0] group_head(
        input logic [ID_W-1:0]  ident,
        input logic [PAT_W-1:0] bits
    );
        return {4'b1100, ident, bits};
    endfunction

    function automatic logic [WORD_W-1:0] info_head(
        input logic [MOD_W-1:0] unit,
        input info_code_e       code,
        input logic [TS_W-1:0]  stamp
    );
        return {2'b10, unit, code, stamp[TS_W-1:LOW_TS_W]};
    endfunction

    function automatic logic [WORD_W-1:0] stamp_tail(
        input logic [TS_W-1:0] stamp
    );
        return {4'b0000, stamp[LOW_TS_W-1:0]};
    endfunction

endpackage

// File: rtl/evitem_arb.sv
module evitem_arb
    import evitem_pkg::*;
#(
    parameter int N     = NSRC,
    localparam int IX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic            en,
    output logic [N-1:0]    gnt,
    output logic [IX_W-1:0] idx,
    output logic            any
);

    logic [N:0] blocked;

    assign blocked[0] = ~en;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            assign gnt[gi]         = req[gi] & ~blocked[gi];
            assign blocked[gi + 1] = blocked[gi] | req[gi];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (gnt[i]) idx = IX_W'(i);
        end
    end

    assign any = |gnt;

endmodule

// File: rtl/evitem_track.sv
module evitem_track #(
    parameter int TRACK_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cand,
    input  logic [TRACK_W-1:0] tag,
    input  logic               bypass,
    input  logic               take,
    output logic               tag_ok,
    output logic               lost
);

    logic [TRACK_W-1:0] expect_q;
    logic               lost_q;

    assign tag_ok = bypass || (tag == expect_q);
    assign lost   = lost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_q <= '0;
            lost_q   <= 1'b0;
        end else begin
            if (take) expect_q <= expect_q + 1'b1;
            if (cand && !tag_ok) lost_q <= 1'b1;
        end
    end

endmodule

// File: rtl/evitem_ser.sv
module evitem_ser
    import evitem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  item_t             item,
    input  logic              out_rdy,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word,
    output logic              idle
);

    phase_e ph_q;
    item_t  hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            hold_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (load) begin
                    ph_q   <= PH_HEAD;
                    hold_q <= item;
                end
                PH_HEAD: if (out_rdy) ph_q <= PH_TAIL;
                PH_TAIL: if (out_rdy) ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign idle     = (ph_q == PH_IDLE);
    assign out_vld  = !idle;
    assign out_word = (ph_q == PH_TAIL) ? hold_q.tail : hold_q.head;

endmodule

// File: rtl/evitem_fmt.sv
module evitem_fmt
    import evitem_pkg::*;
#(
    parameter int TRACK_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_vld,
    output logic               sync_rdy,
    input  logic [47:0]        sync_stamp,
    input  logic [TRACK_W-1:0] sync_tag,
    input  logic               flow_vld,
    output logic               flow_rdy,
    input  logic               flow_resume,
    input  logic [47:0]        flow_stamp,
    input  logic [TRACK_W-1:0] flow_tag,
    input  logic               ga_vld,
    output logic               ga_rdy,
    input  logic [15:0]        ga_bits,
    input  logic [47:0]        ga_stamp,
    input  logic [TRACK_W-1:0] ga_tag,
    input  logic               gb_vld,
    output logic               gb_rdy,
    input  logic [15:0]        gb_bits,
    input  logic [47:0]        gb_stamp,
    input  logic [TRACK_W-1:0] gb_tag,
    input  logic [11:0]        ga_ident,
    input  logic [11:0]        gb_ident,
    input  logic [5:0]         unit_id,
    input  logic               track_bypass,
    output logic               item_vld,
    input  logic               item_rdy,
    output logic [31:0]        item_word,
    output logic               track_lost
);

    logic [NSRC-1:0]              req_v;
    logic [NSRC-1:0]              gnt_v;
    logic [NSRC-1:0][TS_W-1:0]    stamp_v;
    logic [NSRC-1:0][TRACK_W-1:0] tag_v;
    logic [SRC_W-1:0]             gidx;
    logic                         gany;
    logic                         idle;
    logic                         tag_ok;
    logic                         take;
    logic [TS_W-1:0]              sel_stamp;
    item_t                        next_item;

    // index order sets priority
    assign req_v   = {gb_vld, ga_vld, flow_vld, sync_vld};
    assign stamp_v = {gb_stamp, ga_stamp, flow_stamp, sync_stamp};
    assign tag_v   = {gb_tag, ga_tag, flow_tag, sync_tag};

    evitem_arb #(.N(NSRC)) u_arb (
        .req (req_v),
        .en  (idle && !track_lost),
        .gnt (gnt_v),
        .idx (gidx),
        .any (gany)
    );

    evitem_track #(.TRACK_W(TRACK_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .cand   (gany),
        .tag    (tag_v[gidx]),
        .bypass (track_bypass),
        .take   (take),
        .tag_ok (tag_ok),
        .lost   (track_lost)
    );

    assign take = gany && tag_ok;

    assign sync_rdy = gnt_v[SRC_SYNC] && take;
    assign flow_rdy = gnt_v[SRC_FLOW] && take;
    assign ga_rdy   = gnt_v[SRC_GA]   && take;
    assign gb_rdy   = gnt_v[SRC_GB]   && take;

    assign sel_stamp = stamp_v[gidx];

    always_comb begin
        next_item.tail = stamp_tail(sel_stamp);
        unique case (src_e'(gidx))
            SRC_SYNC: next_item.head = info_head(unit_id, CODE_SYNC, sel_stamp);
            SRC_FLOW: next_item.head = info_head(unit_id,
                          flow_resume ? CODE_RESUME : CODE_PAUSE, sel_stamp);
            SRC_GA:   next_item.head = group_head(ga_ident, ga_bits);
            SRC_GB:   next_item.head = group_head(gb_ident, gb_bits);
            default:  next_item.head = info_head(unit_id, CODE_UNDEF, sel_stamp);
        endcase
    end

    evitem_ser u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .item     (next_item),
        .out_rdy  (item_rdy),
        .out_vld  (item_vld),
        .out_word (item_word),
        .idle     (idle)
    );

endmodule

// File: rtl/evitem_fmt_chk.sv
module evitem_fmt_chk #(
    parameter int TRACK_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               sync_vld,
    input logic               sync_rdy,
    input logic [47:0]        sync_stamp,
    input logic [TRACK_W-1:0] sync_tag,
    input logic               flow_vld,
    input logic               flow_rdy,
    input logic               flow_resume,
    input logic [47:0]        flow_stamp,
    input logic [TRACK_W-1:0] flow_tag,
    input logic               ga_vld,
    input logic               ga_rdy,
    input logic [15:0]        ga_bits,
    input logic [47:0]        ga_stamp,
    input logic [TRACK_W-1:0] ga_tag,
    input logic               gb_vld,
    input logic               gb_rdy,
    input logic [15:0]        gb_bits,
    input logic [47:0]        gb_stamp,
    input logic [TRACK_W-1:0] gb_tag,
    input logic [11:0]        ga_ident,
    input logic [11:0]        gb_ident,
    input logic [5:0]         unit_id,
    input logic               track_bypass,
    input logic               item_vld,
    input logic               item_rdy,
    input logic [31:0]        item_word,
    input logic               track_lost
);

    logic [3:0] rdy_v;
    logic       second_q;

    assign rdy_v = {gb_rdy, ga_rdy, flow_rdy, sync_rdy};

    always_ff @(posedge clk) begin
        if (rst) second_q <= 1'b0;
        else if (item_vld && item_rdy) second_q <= ~second_q;
    end

    // R2
    ga_head_chk: assert property (@(posedge clk) disable iff (rst)
        ga_rdy |=> item_word[31:28] == 4'hC && item_word[27:16] == $past(ga_ident)
                   && item_word[15:0] == $past(ga_bits));

    // R4
    sync_head_chk: assert property (@(posedge clk) disable iff (rst)
        sync_rdy |=> item_word[31:30] == 2'b10 && item_word[29:24] == $past(unit_id)
                     && item_word[19:0] == $past(sync_stamp[47:28]));

    // R5
    flow_code_chk: assert property (@(posedge clk) disable iff (rst)
        flow_rdy |=> item_word[23:20] == ($past(flow_resume) ? 4'd3 : 4'd2));

    // R3
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        item_vld && second_q |-> item_word[31:28] == 4'h0);

    // R6
    head_first_chk: assert property (@(posedge clk) disable iff (rst)
        item_vld && !second_q |-> item_word[31]);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        item_vld && !item_rdy |=> item_vld && $stable(item_word));

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rdy_v));

    // R11
    busy_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy_v != 4'b0) |-> !item_vld);

    // R9
    lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        track_lost |=> track_lost);

    // R9
    lost_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        track_lost |-> rdy_v == 4'b0);

    // R10
    bypass_take_chk: assert property (@(posedge clk) disable iff (rst)
        track_bypass && !track_lost && !item_vld && (sync_vld || flow_vld || ga_vld || gb_vld)
        |-> rdy_v != 4'b0);

endmodule

bind evitem_fmt evitem_fmt_chk #(.TRACK_W(TRACK_W)) u_chk (.*);

// File: tb/evitem_fmt_bench.sv
`timescale 1ns/1ps
module evitem_fmt_bench;

    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_vld = 0, flow_vld = 0, ga_vld = 0, gb_vld = 0;
    logic          sync_rdy, flow_rdy, ga_rdy, gb_rdy;
    logic [47:0]   sync_stamp = '0, flow_stamp = '0, ga_stamp = '0, gb_stamp = '0;
    logic [TW-1:0] sync_tag = '0, flow_tag = '0, ga_tag = '0, gb_tag = '0;
    logic          flow_resume = 0;
    logic [15:0]   ga_bits = '0, gb_bits = '0;
    logic [11:0]   ga_ident = 12'hA5C, gb_ident = 12'h3B1;
    logic [5:0]    unit_id = 6'h2D;
    logic          track_bypass = 0;
    logic          item_vld, item_rdy = 0;
    logic [31:0]   item_word;
    logic          track_lost;

    int            n_chk = 0, n_bad = 0;
    int            tagc = 0;
    logic          stall_en = 0;
    int            stall_cnt = 0;
    logic [31:0]   exp_q[$];
    string         req_q[$];

    always #4 clk = ~clk;

    evitem_fmt #(.TRACK_W(TW)) u_evitem_fmt (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // downstream ready, changed on falling edge
    always @(negedge clk) begin
        stall_cnt++;
        item_rdy = stall_en ? ((stall_cnt % 3) != 0) : 1'b1;
    end

    // scoreboard monitor: value seen here is what the next rising edge takes
    always @(negedge clk) begin
        #2;
        if (!rst && item_vld && item_rdy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected word", item_word, 32'h0);
            end else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(item_word === e, r, item_word, e);
            end
        end
    end

    function automatic logic [31:0] tail_of(input logic [47:0] ts);
        return {4'h0, ts[27:0]};
    endfunction

    task automatic put_sync(input logic [47:0] ts);
        sync_stamp = ts; sync_tag = TW'(tagc); tagc++;
        exp_q.push_back({2'b10, unit_id, 4'd4, ts[47:28]}); req_q.push_back("R4/R5 sync head");
        exp_q.push_back(tail_of(ts)); req_q.push_back("R3 sync tail");
    endtask

    task automatic put_flow(input logic res, input logic [47:0] ts);
        flow_stamp = ts; flow_resume = res; flow_tag = TW'(tagc); tagc++;
        exp_q.push_back({2'b10, unit_id, res ? 4'd3 : 4'd2, ts[47:28]}); req_q.push_back("R4/R5 flow head");
        exp_q.push_back(tail_of(ts)); req_q.push_back("R3 flow tail");
    endtask

    task automatic put_ga(input logic [15:0] b, input logic [47:0] ts);
        ga_bits = b; ga_stamp = ts; ga_tag = TW'(tagc); tagc++;
        exp_q.push_back({4'hC, ga_ident, b}); req_q.push_back("R2 group A head");
        exp_q.push_back(tail_of(ts)); req_q.push_back("R3 group A tail");
    endtask

    task automatic put_gb(input logic [15:0] b, input logic [47:0] ts);
        gb_bits = b; gb_stamp = ts; gb_tag = TW'(tagc); tagc++;
        exp_q.push_back({4'hC, gb_ident, b}); req_q.push_back("R2 group B head");
        exp_q.push_back(tail_of(ts)); req_q.push_back("R3 group B tail");
    endtask

    // present masked sources (bit0 sync .. bit3 group B) until all are taken
    task automatic apply(input logic [3:0] mask);
        logic [3:0] pend;
        logic [3:0] got;
        pend = mask;
        @(negedge clk);
        {gb_vld, ga_vld, flow_vld, sync_vld} = pend;
        while (pend != 4'b0) begin
            #1;
            got = {gb_rdy, ga_rdy, flow_rdy, sync_rdy};
            // R7 at most one producer taken per cycle
            check($countones(got) <= 1, "R7 grant count", {28'h0, got}, 32'h0);
            // R11 no record taken while an item is out
            check(!(item_vld && got != 4'b0), "R11 take while busy", {31'h0, item_vld}, 32'h0);
            @(negedge clk);
            pend = pend & ~got;
            {gb_vld, ga_vld, flow_vld, sync_vld} = pend;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (exp_q.size() != 0 || item_vld); i++) @(negedge clk);
        check(exp_q.size() == 0, "R6 items drained", exp_q.size(), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check(item_vld == 1'b0, "R1 item_vld after reset", {31'h0, item_vld}, 32'h0);
        check(track_lost == 1'b0, "R1 track_lost after reset", {31'h0, track_lost}, 32'h0);

        // single items of each kind
        put_ga(16'hBEEF, 48'h1234_5678_9ABC); apply(4'b0100);
        put_gb(16'h0F0F, 48'hFEDC_BA98_7654); apply(4'b1000);
        put_sync(48'h8000_0000_0001);         apply(4'b0001);
        put_flow(1'b0, 48'h0ABC_DEF0_1234);   apply(4'b0010);
        put_flow(1'b1, 48'h7FFF_FFFF_FFFF);   apply(4'b0010);
        drain();

        // R7 all four at once; tags numbered in expected service order
        put_sync(48'h1111_2222_3333);
        put_flow(1'b1, 48'h4444_5555_6666);
        put_ga(16'h1357, 48'h7777_8888_9999);
        put_gb(16'h2468, 48'hAAAA_BBBB_CCCC);
        apply(4'b1111);
        drain();

        // R6 with downstream stalls, R8 count wrap past 16
        stall_en = 1;
        for (int k = 0; k < 20; k++) begin
            if (k % 2 == 0) begin
                put_ga(16'(k * 16'h0901), 48'(k) * 48'h0000_1357_9BDF);
                apply(4'b0100);
            end else begin
                put_gb(16'(k * 16'h1103), 48'(k) * 48'h0246_8ACE_0001);
                apply(4'b1000);
            end
        end
        put_sync(48'h0000_0000_0000); put_ga(16'hFFFF, 48'hFFFF_FFFF_FFFF); apply(4'b0101);
        drain();
        stall_en = 0;

        // R10 bypass: wrong tag still taken, count still advances
        track_bypass = 1;
        @(negedge clk);
        put_ga(16'h5A5A, 48'h0101_0202_0303);
        ga_tag = ga_tag + 4'd7;
        apply(4'b0100);
        drain();
        #1;
        check(track_lost == 1'b0, "R10 no lost under bypass", {31'h0, track_lost}, 32'h0);
        track_bypass = 0;
        // R8 counter advanced over the bypassed record
        put_gb(16'hC3C3, 48'h0F0F_0F0F_0F0F); apply(4'b1000);
        drain();
        #1;
        check(track_lost == 1'b0, "R8 count continues", {31'h0, track_lost}, 32'h0);

        // R9 mismatch halts
        @(negedge clk);
        ga_bits = 16'h9999; ga_stamp = 48'h1; ga_tag = TW'(tagc + 5); ga_vld = 1;
        #1;
        check(ga_rdy == 1'b0, "R9 bad tag refused", {31'h0, ga_rdy}, 32'h0);
        @(negedge clk); #1;
        check(track_lost == 1'b1, "R9 lost raised", {31'h0, track_lost}, 32'h1);
        ga_tag = TW'(tagc);
        #1;
        check(ga_rdy == 1'b0, "R9 sticky refuse", {31'h0, ga_rdy}, 32'h0);
        repeat (4) @(negedge clk);
        #1;
        check(item_vld == 1'b0, "R9 no output after halt", {31'h0, item_vld}, 32'h0);
        check(track_lost == 1'b1, "R9 lost held", {31'h0, track_lost}, 32'h1);
        ga_vld = 0;

        // R1 reset clears, count back to 0
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0; tagc = 0;
        #1;
        check(track_lost == 1'b0, "R1 lost cleared by reset", {31'h0, track_lost}, 32'h0);
        put_flow(1'b0, 48'h2222_3333_4444); apply(4'b0010);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule